// File: doc/BRIEF.md
# Single-Bus Control-Step Processor Core

This block is a small processor core in which every transfer between registers crosses one shared internal bus. A hardwired sequencer advances a control-step counter by one step per clock. In each step it selects at most one bus source and raises the load enables of the registers that capture the bus. The core fetches 16-bit instruction words from an external memory and executes two instructions. A register-to-register add writes its sum back into the first-named register. A load copies a memory word into a register. Any other opcode is treated as a no-operation.

The memory side has an address, a read request that stays high until the memory finishes, returned read data, and a one-cycle completion strobe that can arrive any number of cycles after the request. The program counter is not incremented by a dedicated adder. It goes through the ALU, whose result latch captures PC+1, and the latched value is written back to the PC in the following step. While the core waits for memory, the sequencer holds its current step and loads nothing. Each register-file write is visible on a write-observation port: enable, index and data.

Top module: `sbc_core`

## Requirements
- R1: After reset the read request and the register write enable are low, all registers hold zero, and the first read requested is at address 0.
- R2: Instruction fetches read consecutive addresses starting from 0. The PC advances by exactly one per instruction, taking its new value from the ALU result latch one step after the increment.
- R3: The read request stays high with a stable address until the completion strobe. While a read is outstanding the core writes no register, and the fetched word reaches the instruction register only after completion.
- R4: An instruction word has the opcode in bits 15:12, the destination register in bits 11:10, the source register in bits 9:8 and the memory address in bits 7:0. Opcode 4'h1 is ADD and 4'h2 is LOAD. Fields that an opcode does not use are ignored.
- R5: ADD sets Rd to (Rd + Rs) mod 2^16. This holds when Rd equals Rs, and the write carries the destination index from bits 11:10.
- R6: LOAD issues a read at the 8-bit address field and writes the returned word into Rd.
- R7: Every opcode other than 4'h1 and 4'h2 writes no register. The next fetch request appears four cycles after the instruction word's completion strobe.
- R8: Every step that loads any register or latch has exactly one bus driver enabled.
- R9: Writeback timing is fixed relative to the completion strobe. An ADD writes four cycles after its instruction word's completion strobe. A LOAD writes two cycles after its operand's completion strobe. Both instructions end at step 5, and the counter then returns to step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | AW (8) | Memory read address, taken from the address register |
| mem_rd_o | output | 1 | Read request, held until completion |
| mem_rdata_i | input | DW (16) | Read data, valid with mem_done_i |
| mem_done_i | input | 1 | One-cycle read completion strobe |
| wb_en_o | output | 1 | Register-file write this cycle |
| wb_idx_o | output | RW (2) | Register-file write index |
| wb_data_o | output | DW (16) | Register-file write data (bus value) |

## Verification
The memory model varies completion latency from one to five cycles across requests. This exposes a sequencer that advances before the strobe or moves stale data into the instruction register; such a design would show wrong fetch addresses, early writebacks or wrong register values. Every destination/source pair of ADD is swept, including self-add and a 0xFFFF+1 wrap. A design that read the same operand twice or kept a carry would produce a mismatched sum. Instruction words carry junk in their unused fields, and several undefined opcodes are included, so a decoder that looks at the wrong bits or writes on a no-operation produces extra or misplaced writes. Writeback and next-fetch cycles are measured against each completion strobe, which catches any step added to or dropped from the sequences.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int unsigned OPW = 4;
  localparam logic [OPW-1:0] OP_ADD  = 4'h1;
  localparam logic [OPW-1:0] OP_LOAD = 4'h2;

  // bus sources; SRC_NONE leaves the bus idle
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_PC   = 3'd1,
    SRC_Z    = 3'd2,
    SRC_MDR  = 3'd3,
    SRC_IRA  = 3'd4,
    SRC_RF   = 3'd5
  } bus_src_e;
  localparam int unsigned NSRC = 5;

  typedef struct packed {
    bus_src_e src;
    logic     rf_sel_src; // 0: read dst field, 1: read src field
    logic     pc_in;
    logic     mar_in;
    logic     ir_in;
    logic     y_in;
    logic     z_in;
    logic     rf_in;
    logic     alu_inc;    // 1: bus+1, 0: y+bus
    logic     rd_req;
    logic     mdr_take;
  } ctl_t;
endpackage

// File: rtl/sbc_regfile.sv
module sbc_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 4,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= '0;
      else if (we_i && waddr_i == RW'(g))       regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
  import sbc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] op_i,
  input  logic           mdr_vld_i,
  output ctl_t           ctl_o,
  output logic           stall_o
);
  localparam int unsigned STEPW = 3;
  localparam logic [STEPW-1:0] LAST = STEPW'(5);

  logic [STEPW-1:0] step_q, step_d;
  logic is_add, is_load;

  assign is_add  = (op_i == OP_ADD);
  assign is_load = (op_i == OP_LOAD);

  always_comb begin
    ctl_o   = '0;
    stall_o = 1'b0;
    step_d  = step_q + STEPW'(1);
    unique case (step_q)
      3'd0: begin
        ctl_o.src = SRC_PC; ctl_o.mar_in = 1'b1; ctl_o.rd_req = 1'b1;
        ctl_o.alu_inc = 1'b1; ctl_o.z_in = 1'b1;
      end
      3'd1: begin
        ctl_o.src = SRC_Z; ctl_o.pc_in = 1'b1;
      end
      3'd2: begin
        if (mdr_vld_i) begin
          ctl_o.src = SRC_MDR; ctl_o.ir_in = 1'b1; ctl_o.mdr_take = 1'b1;
        end else begin
          stall_o = 1'b1;
          step_d  = step_q;
        end
      end
      3'd3: begin
        if (is_add) begin
          ctl_o.src = SRC_RF; ctl_o.y_in = 1'b1;
        end else if (is_load) begin
          ctl_o.src = SRC_IRA; ctl_o.mar_in = 1'b1; ctl_o.rd_req = 1'b1;
        end else begin
          step_d = '0; // no-operation
        end
      end
      3'd4: begin
        if (is_add) begin
          ctl_o.src = SRC_RF; ctl_o.rf_sel_src = 1'b1; ctl_o.z_in = 1'b1;
        end else if (!mdr_vld_i) begin
          stall_o = 1'b1;
          step_d  = step_q;
        end
      end
      3'd5: begin
        ctl_o.rf_in = 1'b1;
        ctl_o.src   = is_add ? SRC_Z : SRC_MDR;
        ctl_o.mdr_take = !is_add;
        step_d = '0;
      end
      default: step_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  a_r9_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST);
  a_r9_wrap_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == LAST |=> step_q == '0);
  a_r7_nop_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == 3'd3 && !is_add && !is_load) |=> step_q == '0);
endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  ctl_t           ctl_i,
  input  logic           stall_i,
  output logic [OPW-1:0] op_o,
  output logic           mdr_vld_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_rd_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_done_i,
  output logic           wb_en_o,
  output logic [RW-1:0]  wb_idx_o,
  output logic [DW-1:0]  wb_data_o
);
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] ir_q, mdr_q, y_q, z_q;
  logic          rd_pend_q, mdr_vld_q;
  logic [DW-1:0] bus, alu_out, rf_rdata;
  logic [RW-1:0] f_dst, f_src, rf_raddr;
  logic [NSRC-1:0] oe;
  logic [DW-1:0] src_val [NSRC];
  logic          ld_any;

  assign op_o  = ir_q[DW-1 -: OPW];
  assign f_dst = ir_q[DW-OPW-1 -: RW];
  assign f_src = ir_q[DW-OPW-RW-1 -: RW];

  // one-hot bus drivers, ordered as the enum values 1..NSRC
  assign src_val[0] = DW'(pc_q);
  assign src_val[1] = z_q;
  assign src_val[2] = mdr_q;
  assign src_val[3] = DW'(ir_q[AW-1:0]);
  assign src_val[4] = rf_rdata;

  for (genvar g = 0; g < NSRC; g++) begin : g_oe
    assign oe[g] = (ctl_i.src == bus_src_e'(3'(g + 1)));
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) if (oe[i]) bus = bus | src_val[i];
  end

  assign alu_out  = ctl_i.alu_inc ? bus + DW'(1) : y_q + bus;
  assign rf_raddr = ctl_i.rf_sel_src ? f_src : f_dst;

  sbc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_i.rf_in),
    .waddr_i (f_dst),
    .wdata_i (bus),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; mar_q <= '0; ir_q <= '0; y_q <= '0; z_q <= '0;
    end else begin
      if (ctl_i.pc_in)  pc_q  <= bus[AW-1:0];
      if (ctl_i.mar_in) mar_q <= bus[AW-1:0];
      if (ctl_i.ir_in)  ir_q  <= bus;
      if (ctl_i.y_in)   y_q   <= bus;
      if (ctl_i.z_in)   z_q   <= alu_out;
    end
  end

  // memory handshake: request held until the completion strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0; mdr_vld_q <= 1'b0; mdr_q <= '0;
    end else begin
      if (rd_pend_q && mem_done_i) begin
        rd_pend_q <= 1'b0;
        mdr_q     <= mem_rdata_i;
        mdr_vld_q <= 1'b1;
      end else begin
        if (ctl_i.rd_req)   rd_pend_q <= 1'b1;
        if (ctl_i.mdr_take) mdr_vld_q <= 1'b0;
      end
    end
  end

  assign mdr_vld_o  = mdr_vld_q;
  assign mem_addr_o = mar_q;
  assign mem_rd_o   = rd_pend_q;
  assign wb_en_o    = ctl_i.rf_in;
  assign wb_idx_o   = f_dst;
  assign wb_data_o  = bus;

  assign ld_any = ctl_i.pc_in | ctl_i.mar_in | ctl_i.ir_in | ctl_i.y_in |
                  ctl_i.z_in | ctl_i.rf_in;

  a_r2_pc_plus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.pc_in |=> pc_q == $past(pc_q) + AW'(1));
  a_r3_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(pc_q) && $stable(ir_q) && $stable(y_q) &&
                 $stable(z_q) && $stable(mar_q)));
  a_r3_ir_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.ir_in |-> mdr_vld_q);
  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend_q && !mem_done_i) |=> (mem_rd_o && $stable(mem_addr_o)));
  a_r8_load_has_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_any |-> $onehot(oe));
endmodule

// File: rtl/sbc_core.sv
module sbc_core
  import sbc_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 8,
  parameter int unsigned NREG = 4,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_done_i,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [DW-1:0] wb_data_o
);
  ctl_t           ctl;
  logic [OPW-1:0] op;
  logic           mdr_vld, stall;

  sbc_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .mdr_vld_i (mdr_vld),
    .ctl_o     (ctl),
    .stall_o   (stall)
  );

  sbc_datapath #(.DW(DW), .AW(AW), .NREG(NREG)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .stall_i     (stall),
    .op_o        (op),
    .mdr_vld_o   (mdr_vld),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_done_i  (mem_done_i),
    .wb_en_o     (wb_en_o),
    .wb_idx_o    (wb_idx_o),
    .wb_data_o   (wb_data_o)
  );

  a_r3_no_write_while_reading: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !wb_en_o);
endmodule

// File: tb/sbc_core_tb.sv
module sbc_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  mem_addr_o;
  logic        mem_rd_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_done_i = 1'b0;
  logic        wb_en_o;
  logic [1:0]  wb_idx_o;
  logic [15:0] wb_data_o;

  always #5 clk_i = ~clk_i;

  sbc_core dut_i (.*);

  logic [15:0] mem [256];
  int exp_addr [512];
  int exp_kind [512]; // 0 fetch add, 1 fetch load, 2 fetch nop, 3 operand
  int exp_widx [512];
  int exp_wdat [512];
  int n_rd = 0, n_wb = 0, n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wb_cnt = 0, req_n = 0, cyc = 0;
  int done_cyc = 0, done_kind = 0;
  bit mon_on = 0, prev_rd = 0, timeout = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [1:0] d,
                                      input logic [1:0] s, input logic [7:0] a);
    return {op, d, s, a};
  endfunction

  // memory model: completion latency cycles through 1..5
  int busy_cnt = 0;
  logic [7:0] lat_addr = '0;
  always @(posedge clk_i) begin
    cyc = cyc + 1;
    mem_done_i <= 1'b0;
    if (busy_cnt > 0) begin
      if (busy_cnt == 1) begin
        mem_done_i  <= 1'b1;
        mem_rdata_i <= mem[lat_addr];
      end
      busy_cnt = busy_cnt - 1;
    end else if (mem_rd_o && !mem_done_i) begin
      busy_cnt = 1 + (req_n % 5);
      req_n    = req_n + 1;
      lat_addr = mem_addr_o;
    end
  end

  // monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (mem_done_i) begin
        done_cyc  = cyc;
        done_kind = (rd_cnt > 0) ? exp_kind[rd_cnt-1] : 0;
      end
      if (mem_rd_o && !prev_rd) begin
        if (rd_cnt == 0)
          chk(mem_addr_o == 8'h00, "R1 first fetch address", int'(mem_addr_o), 0);
        else if (exp_kind[rd_cnt-1] == 2)
          chk(cyc == done_cyc + 4, "R7 fetch after nop cycle", cyc, done_cyc + 4);
        if (rd_cnt < n_rd) begin
          if (exp_kind[rd_cnt] == 3)
            chk(int'(mem_addr_o) == exp_addr[rd_cnt], "R6 operand address",
                int'(mem_addr_o), exp_addr[rd_cnt]);
          else
            chk(int'(mem_addr_o) == exp_addr[rd_cnt], "R2 fetch address",
                int'(mem_addr_o), exp_addr[rd_cnt]);
        end
        rd_cnt++;
      end
      if (mem_rd_o && wb_en_o)
        chk(1'b0, "R3 write during outstanding read", 1, 0);
      if (wb_en_o) begin
        if (wb_cnt < n_wb) begin
          chk(int'(wb_idx_o) == exp_widx[wb_cnt], "R5 write index",
              int'(wb_idx_o), exp_widx[wb_cnt]);
          if (done_kind == 3)
            chk(int'(wb_data_o) == exp_wdat[wb_cnt], "R6 load data",
                int'(wb_data_o), exp_wdat[wb_cnt]);
          else
            chk(int'(wb_data_o) == exp_wdat[wb_cnt], "R5 add sum",
                int'(wb_data_o), exp_wdat[wb_cnt]);
          if (done_kind == 3)
            chk(cyc == done_cyc + 2, "R9 load writeback cycle", cyc, done_cyc + 2);
          else
            chk(cyc == done_cyc + 4, "R9 add writeback cycle", cyc, done_cyc + 4);
        end else begin
          chk(1'b0, "R7 unexpected register write", int'(wb_idx_o), -1);
        end
        wb_cnt++;
      end
      prev_rd = mem_rd_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    timeout = 1;
  end

  initial begin
    int pc = 0;
    logic [15:0] rf [4];
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 16; i++) mem[8'hC0 + i] = 16'(i * 16'h1357 + 16'h0F0F);
    mem[8'hC4] = 16'hFFFF;
    mem[8'hC5] = 16'h0001;
    mem[8'hC6] = 16'h8000;
    // R4: unused fields carry junk (ADD addr field, LOAD src field)
    for (int r = 0; r < 4; r++) begin mem[pc] = enc(4'h2, 2'(r), 2'd3, 8'(8'hC0 + r)); pc++; end
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++) begin mem[pc] = enc(4'h1, 2'(d), 2'(s), 8'hA5); pc++; end
    mem[pc] = enc(4'h0, 2'd1, 2'd2, 8'hC4); pc++;
    mem[pc] = enc(4'h3, 2'd0, 2'd0, 8'hC5); pc++;
    mem[pc] = enc(4'hF, 2'd3, 2'd3, 8'hFF); pc++;
    mem[pc] = enc(4'h2, 2'd2, 2'd0, 8'hC4); pc++;
    mem[pc] = enc(4'h2, 2'd3, 2'd1, 8'hC5); pc++;
    mem[pc] = enc(4'h1, 2'd2, 2'd3, 8'h00); pc++; // wrap to 0
    for (int i = 0; i < 16; i++) begin
      mem[pc] = enc(4'h2, 2'(i % 4), 2'(i % 3), 8'(8'hC0 + i)); pc++;
      mem[pc] = enc(4'h1, 2'(i % 4), 2'((i + 1) % 4), 8'(i)); pc++;
    end
    // reference model
    for (int r = 0; r < 4; r++) rf[r] = '0;
    for (int a = 0; a < pc; a++) begin
      logic [15:0] w;
      w = mem[a];
      exp_addr[n_rd] = a;
      if (w[15:12] == 4'h1) begin
        exp_kind[n_rd] = 0; n_rd++;
        rf[w[11:10]] = rf[w[11:10]] + rf[w[9:8]];
        exp_widx[n_wb] = int'(w[11:10]); exp_wdat[n_wb] = int'(rf[w[11:10]]); n_wb++;
      end else if (w[15:12] == 4'h2) begin
        exp_kind[n_rd] = 1; n_rd++;
        exp_addr[n_rd] = int'(w[7:0]); exp_kind[n_rd] = 3; n_rd++;
        rf[w[11:10]] = mem[w[7:0]];
        exp_widx[n_wb] = int'(w[11:10]); exp_wdat[n_wb] = int'(rf[w[11:10]]); n_wb++;
      end else begin
        exp_kind[n_rd] = 2; n_rd++;
      end
    end

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(mem_rd_o == 1'b0, "R1 reset read request", int'(mem_rd_o), 0);
    chk(wb_en_o == 1'b0, "R1 reset write enable", int'(wb_en_o), 0);
    chk(mem_addr_o == 8'h00, "R1 reset address", int'(mem_addr_o), 0);
    mon_on = 1;
    rst_ni = 1'b1;

    wait (rd_cnt > n_rd || timeout);
    @(negedge clk_i);
    if (timeout) chk(1'b0, "R3 watchdog expired", rd_cnt, n_rd + 1);
    chk(wb_cnt == n_wb, "R7 total register writes", wb_cnt, n_wb);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule